// File: doc/BRIEF.md
# ECC Error Status Reporter

This block collects error-correction events from two memory sources, a RAM and a flash array, and turns them into one status byte, one set of captured details per source and an interrupt request. Each source reports two kinds of event: a single-bit error that was corrected, and an error that could not be corrected. That gives four event categories, each with its own enable bit. An enabled event sets its category's flag in the status byte. It also loads that source's capture registers with the address, attributes and data carried by the event.

Only one flag can be set at any time, so the flag always matches the latest capture. When a newer enabled event arrives, it replaces the pending flag in the same clock edge. If several enabled events arrive together, a fixed priority picks one of them. Software reads the status byte and the capture registers over a small register port. It clears the flag by writing a 1 to that flag's bit. Reads have no side effects.

Top module: `ecc_status_reporter`

## Requirements
- R1: After reset the status byte is 0x00, every capture register is 0 and `irq` is low.
- R2: An event pulse whose category enable is high sets the category's flag at the next clock edge. The flag positions in the status byte (bit 0 = LSB) are:
  - bit 5: RAM corrected
  - bit 4: flash corrected
  - bit 1: RAM uncorrectable
  - bit 0: flash uncorrectable

  The `evt` and `en` index order is: 0 RAM corrected, 1 flash corrected, 2 RAM uncorrectable, 3 flash uncorrectable.
- R3: An event whose category enable is low changes neither the status byte nor any capture register.
- R4: At most one status bit is set at any time. A new enabled event clears the pending flag and sets its own flag at the same edge.
- R5: An enabled event that is selected loads its own source's address, attribute and data captures from that source's payload. The other source's captures keep their values.
- R6: When several enabled events arrive in the same cycle, exactly one is flagged and captured. The priority order is: RAM uncorrectable, then flash uncorrectable, then RAM corrected, then flash corrected.
- R7: A write to register 0 clears each status bit that has a 1 in the write data. Bits written with 0 keep their value. Writes to any other register leave the status byte unchanged.
- R8: If an enabled event and a clearing write to register 0 occur in the same cycle, only the event's flag is set after the edge.
- R9: `irq` is high exactly while some category has both its status flag and its enable set.
- R10: The read map is:
  - 0: status
  - 1, 2, 3: RAM address, attributes, data
  - 4, 5, 6: flash address, attributes, data
  - 7: reads 0

  Values are zero-extended to the read width. Status bits 7, 6, 3 and 2 always read 0. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 4 | Per-category enables (index order as in R2) |
| evt | input | 4 | Per-category event pulses (index order as in R2) |
| ram_addr | input | ADDR_W | RAM event address |
| ram_attr | input | ATTR_W | RAM event attributes |
| ram_data | input | DATA_W | RAM event data |
| flash_addr | input | ADDR_W | Flash event address |
| flash_attr | input | ATTR_W | Flash event attributes |
| flash_data | input | DATA_W | Flash event data |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Access is a write |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | RD_W | Read data, zero-extended |
| irq | output | 1 | Interrupt request |
| status | output | 8 | Status byte |
| ram_addr_q | output | ADDR_W | Captured RAM address |
| ram_attr_q | output | ATTR_W | Captured RAM attributes |
| ram_data_q | output | DATA_W | Captured RAM data |
| flash_addr_q | output | ADDR_W | Captured flash address |
| flash_attr_q | output | ATTR_W | Captured flash attributes |
| flash_data_q | output | DATA_W | Captured flash data |

## Verification
The bench builds the block with ADDR_W=12, ATTR_W=6 and DATA_W=20, so the three payload fields all have different widths and the read port is 20 bits wide. With these widths, reading each register checks that it comes from the right field and that the narrower fields are zero-extended. The payloads change from one event to the next. This makes a stale or cross-wired capture visible, as well as a priority pick that loads the wrong source.

// File: rtl/ecc_status_reporter.sv
module ecc_status_reporter #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32,
  localparam int W1 = (ADDR_W > ATTR_W) ? ADDR_W : ATTR_W,
  localparam int W2 = (W1 > DATA_W) ? W1 : DATA_W,
  localparam int RD_W = (W2 > 8) ? W2 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        en,
  input  logic [3:0]        evt,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [ATTR_W-1:0] ram_attr,
  input  logic [DATA_W-1:0] ram_data,
  input  logic [ADDR_W-1:0] flash_addr,
  input  logic [ATTR_W-1:0] flash_attr,
  input  logic [DATA_W-1:0] flash_data,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              irq,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] ram_addr_q,
  output logic [ATTR_W-1:0] ram_attr_q,
  output logic [DATA_W-1:0] ram_data_q,
  output logic [ADDR_W-1:0] flash_addr_q,
  output logic [ATTR_W-1:0] flash_attr_q,
  output logic [DATA_W-1:0] flash_data_q
);

  logic [3:0] hit, win;
  logic [7:0] flag_img, status_d;
  logic       clr, ram_load, flash_load;

  assign hit = evt & en;

  always_comb begin
    win = 4'b0000;
    if      (hit[2]) win = 4'b0100;
    else if (hit[3]) win = 4'b1000;
    else if (hit[0]) win = 4'b0001;
    else if (hit[1]) win = 4'b0010;
  end

  assign flag_img   = {2'b00, win[0], win[1], 2'b00, win[2], win[3]};
  assign clr        = reg_sel && reg_wr && (reg_addr == 3'd0);
  assign ram_load   = win[0] | win[2];
  assign flash_load = win[1] | win[3];

  always_comb begin
    if (|hit)     status_d = flag_img;
    else if (clr) status_d = status & ~reg_wdata;
    else          status_d = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status       <= '0;
      ram_addr_q   <= '0;
      ram_attr_q   <= '0;
      ram_data_q   <= '0;
      flash_addr_q <= '0;
      flash_attr_q <= '0;
      flash_data_q <= '0;
    end else begin
      status <= status_d;
      if (ram_load) begin
        ram_addr_q <= ram_addr;
        ram_attr_q <= ram_attr;
        ram_data_q <= ram_data;
      end
      if (flash_load) begin
        flash_addr_q <= flash_addr;
        flash_attr_q <= flash_attr;
        flash_data_q <= flash_data;
      end
    end
  end

  assign irq = |({status[0], status[1], status[4], status[5]} & en);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[7:0]        = status;
      3'd1: reg_rdata[ADDR_W-1:0] = ram_addr_q;
      3'd2: reg_rdata[ATTR_W-1:0] = ram_attr_q;
      3'd3: reg_rdata[DATA_W-1:0] = ram_data_q;
      3'd4: reg_rdata[ADDR_W-1:0] = flash_addr_q;
      3'd5: reg_rdata[ATTR_W-1:0] = flash_attr_q;
      3'd6: reg_rdata[DATA_W-1:0] = flash_data_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ecc_status_reporter_chk.sv
module ecc_status_reporter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        en,
  input logic [3:0]        evt,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic              irq,
  input logic [7:0]        status,
  input logic [ADDR_W-1:0] ram_addr_q,
  input logic [ADDR_W-1:0] flash_addr_q
);

  a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'hCC) == 8'h00);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00) |-> !irq);

  a_r3_quiet_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & en) == 4'b0000 && !(reg_sel && reg_wr && reg_addr == 3'd0)) |=> $stable(status));

  a_r6_ram_unc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[2] && en[2]) |=> (status == 8'h02));

  a_r5_ram_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[2] && en[2]) |=> (ram_addr_q == $past(ram_addr)));

  a_r5_flash_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[3] && en[3] && !(evt[2] && en[2])) |=> (flash_addr_q == $past(flash_addr)));

  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & en) != 4'b0000) |=> (status != 8'h00));

endmodule

bind ecc_status_reporter ecc_status_reporter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ecc_status_reporter.sv
`timescale 1ns/1ps
module sim_ecc_status_reporter;
  localparam int AW = 12, TW = 6, DW = 20, RW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] en = '0, evt = '0;
  logic [AW-1:0] ra = '0, fa = '0;
  logic [TW-1:0] rt = '0, ft = '0;
  logic [DW-1:0] rd = '0, fd = '0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic irq;
  logic [7:0] status;
  logic [AW-1:0] ram_addr_q, flash_addr_q;
  logic [TW-1:0] ram_attr_q, flash_attr_q;
  logic [DW-1:0] ram_data_q, flash_data_q;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] e_ra, e_rt, e_rd, e_fa, e_ft, e_fd;

  ecc_status_reporter #(.ADDR_W(AW), .ATTR_W(TW), .DATA_W(DW)) u0 (
    .clk, .rst_n, .en, .evt,
    .ram_addr(ra), .ram_attr(rt), .ram_data(rd),
    .flash_addr(fa), .flash_attr(ft), .flash_data(fd),
    .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .irq, .status, .ram_addr_q, .ram_attr_q, .ram_data_q,
    .flash_addr_q, .flash_attr_q, .flash_data_q);

  always #10 clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [31:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 v = 32'(reg_rdata);
    reg_sel = 1'b0; reg_addr = '0;
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic load(input int s);
    ra = AW'(12'h300 + s); rt = TW'(6'h11 + s); rd = DW'(20'hA0000 + 17 * s);
    fa = AW'(12'h7C0 - s); ft = TW'(6'h2A - s); fd = DW'(20'h05000 + 33 * s);
  endtask

  task automatic note_ram();   e_ra = 32'(ra); e_rt = 32'(rt); e_rd = 32'(rd); endtask
  task automatic note_flash(); e_fa = 32'(fa); e_ft = 32'(ft); e_fd = 32'(fd); endtask

  task automatic fire(input logic [3:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic check_caps(string req);
    logic [31:0] v;
    read_reg(3'd1, v); check(req, "ram addr", v, e_ra);
    read_reg(3'd2, v); check(req, "ram attr", v, e_rt);
    read_reg(3'd3, v); check(req, "ram data", v, e_rd);
    read_reg(3'd4, v); check(req, "flash addr", v, e_fa);
    read_reg(3'd5, v); check(req, "flash attr", v, e_ft);
    read_reg(3'd6, v); check(req, "flash data", v, e_fd);
  endtask

  function automatic logic [7:0] flag_of(int i);
    case (i)
      0: return 8'h20;
      1: return 8'h10;
      2: return 8'h02;
      default: return 8'h01;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "status", 32'(status), 0);
    check("R1", "irq", 32'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      read_reg(3'(a), v); check("R1", "reg read", v, 0);
    end
  endtask

  task automatic t_each_flag();
    en = 4'hF;
    for (int i = 0; i < 4; i++) begin
      load(i);
      fire(4'(1 << i));
      if (i == 0 || i == 2) note_ram(); else note_flash();
      check("R2", "flag position", 32'(status), 32'(flag_of(i)));
      check("R9", "irq with enabled flag", 32'(irq), 1);
      check_caps("R5");
      write_reg(3'd0, flag_of(i));
      check("R7", "cleared by write", 32'(status), 0);
      check("R9", "irq after clear", 32'(irq), 0);
    end
  endtask

  task automatic t_disabled();
    en = 4'b1110;
    load(9);
    fire(4'b0001);
    check("R3", "disabled leaves status", 32'(status), 0);
    check("R3", "disabled leaves irq", 32'(irq), 0);
    check_caps("R3");
    en = 4'hF;
  endtask

  task automatic t_replace();
    load(20); fire(4'b0001); note_ram();
    check("R4", "first flag", 32'(status), 32'h20);
    load(21); fire(4'b1000); note_flash();
    check("R4", "newer replaces older", 32'(status), 32'h01);
    check_caps("R5");
    write_reg(3'd0, 8'h01);
  endtask

  task automatic t_priority();
    load(30); fire(4'b1111); note_ram();
    check("R6", "ram uncorrectable wins", 32'(status), 32'h02);
    check_caps("R6");
    load(31); fire(4'b1011); note_flash();
    check("R6", "flash uncorrectable over corrected", 32'(status), 32'h01);
    load(32); fire(4'b0011); note_ram();
    check("R6", "ram corrected over flash corrected", 32'(status), 32'h20);
    check_caps("R6");
    write_reg(3'd0, 8'hFF);
  endtask

  task automatic t_w1c();
    load(40); fire(4'b0010); note_flash();
    write_reg(3'd0, 8'h00);
    check("R7", "write of zero keeps flag", 32'(status), 32'h10);
    write_reg(3'd0, 8'hEF);
    check("R7", "write of other ones keeps flag", 32'(status), 32'h10);
    write_reg(3'd3, 8'hFF);
    check("R7", "write elsewhere keeps flag", 32'(status), 32'h10);
    write_reg(3'd0, 8'h10);
    check("R7", "write of one clears", 32'(status), 0);
  endtask

  task automatic t_collision();
    load(50); fire(4'b0001); note_ram();
    load(51);
    @(negedge clk);
    evt = 4'b0010; reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hFF;
    @(negedge clk);
    evt = '0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    note_flash();
    check("R8", "event beats clear", 32'(status), 32'h10);
    check_caps("R8");
  endtask

  task automatic t_irq_enable();
    en = 4'b1101;
    #1 check("R9", "irq low with category disabled", 32'(irq), 0);
    check("R9", "flag kept while disabled", 32'(status), 32'h10);
    en = 4'hF;
    #1 check("R9", "irq back when enabled", 32'(irq), 1);
    write_reg(3'd0, 8'h10);
  endtask

  task automatic t_readmap();
    logic [31:0] v;
    load(60); fire(4'b0100); note_ram();
    read_reg(3'd0, v); check("R10", "status read", v, 32'h02);
    read_reg(3'd0, v); check("R10", "second status read", v, 32'h02);
    read_reg(3'd7, v); check("R10", "unused index", v, 0);
    check_caps("R10");
    @(negedge clk);
    check("R10", "reads leave status", 32'(status), 32'h02);
    write_reg(3'd0, 8'h02);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    e_ra = 0; e_rt = 0; e_rd = 0; e_fa = 0; e_ft = 0; e_fd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_each_flag();
    t_disabled();
    t_replace();
    t_priority();
    t_w1c();
    t_collision();
    t_irq_enable();
    t_readmap();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule